// File: doc/BRIEF.md
# Paired Register File with Pointer Stepping

This block holds the general-purpose, temporary, program-counter and stack-pointer storage of a small 8-bit processor. It has twelve bytes arranged as six 16-bit pairs. A 5-bit select reaches either one byte or a whole pair. A sequencer drives one read select and one write select each cycle. The read side places data on a 16-bit output bus. The write side loads from a 16-bit input bus.

Apart from the bus path, the pair named by the write select can be stepped in place. It can be incremented, decremented or advanced by two, with no bus traffic and no write enable. This lets the counter and stack pointer move in the same cycle as other transfers. All six pair values are also driven out at all times so that address logic can use them directly.

Top module: `pair_regfile`

## Requirements
- R1: While rst_ni is low, every byte is cleared, so all six pair outputs read 0x0000, including the program counter and stack pointer.
- R2: With select bit 4 at 0, bits 3:0 give a byte index: B=0, C=1, D=2, E=3, H=4, L=5, W=6, Z=7, PC high=8, PC low=9, SP high=10, SP low=11. A write with wr_en_i high stores bus_i[7:0] into that byte on the rising clock edge. The other byte of the pair keeps its value.
- R3: A byte read with rd_en_i high drives bus_o as {8'h00, byte}, combinationally from the current contents.
- R4: With select bit 4 at 1, bits 3:1 name a pair and bit 0 is ignored: BC=10000, DE=10010, HL=10100, WZ=10110, PC=11000, SP=11010. A pair write loads bus_i[15:8] into the high (even) byte and bus_i[7:0] into the low byte.
- R5: A pair read with rd_en_i high drives the full 16-bit pair value on bus_o, with the high byte in bits 15:8.
- R6: When the write select is a pair code and wr_en_i is low, step_i changes that pair on the clock edge. 01 adds one, 10 subtracts one, 11 adds two and 00 leaves it unchanged. Results wrap modulo 65536.
- R7: When wr_en_i is high and step_i is nonzero in the same cycle, the bus write takes effect and the step is discarded.
- R8: A read of one pair and a write of another in the same cycle both take effect. The read returns the contents before the edge, so WZ can be copied into PC by feeding bus_o back to bus_i.
- R9: With rd_en_i low, bus_o is 0x0000.
- R10: Selects that name no storage are harmless. These are byte indices 12 to 15 and pair codes 11100 to 11111. Reads of them return 0x0000, and writes and steps to them change nothing. A nonzero step_i with a byte write select also changes nothing.
- R11: bc_o, de_o, hl_o, wz_o, pc_o and sp_o always show the current pair contents, high byte in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_i | input | 5 | Read select (byte or pair) |
| rd_en_i | input | 1 | Drive selected value onto bus_o |
| wr_sel_i | input | 5 | Write and step select |
| wr_en_i | input | 1 | Load selected byte or pair from bus_i |
| step_i | input | 2 | Pair step code: 00 none, 01 +1, 10 -1, 11 +2 |
| bus_i | input | 16 | Write data; low byte only for byte writes |
| bus_o | output | 16 | Read data |
| bc_o | output | 16 | BC pair contents |
| de_o | output | 16 | DE pair contents |
| hl_o | output | 16 | HL pair contents |
| wz_o | output | 16 | WZ temporary pair contents |
| pc_o | output | 16 | Program counter contents |
| sp_o | output | 16 | Stack pointer contents |

## Verification
The hardest case to reach is a same-cycle transfer where the read side and the write side share an edge. The value read must be the one from before the edge, even when the read pair is the pair being written. The bench loops bus_o back into bus_i with rd_sel_i on WZ and wr_sel_i on PC, and checks bus_o before the edge and pc_o after it. It then repeats the case with read and write on the same pair. Wrap-around at 0xFFFF and 0x0000 is reached by first loading the pair with the edge value through a pair write, then stepping once.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PAIR_W    = 2 * BYTE_W;
  localparam int unsigned NUM_PAIRS = 6;
  localparam int unsigned NUM_BYTES = 2 * NUM_PAIRS;
  localparam int unsigned SEL_W     = 5;
  localparam int unsigned IDX_W     = SEL_W - 1;
  localparam int unsigned PIDX_W    = IDX_W - 1;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_INC2 = 2'b11
  } step_e;
endpackage

// File: rtl/pr_sel_decode.sv
module pr_sel_decode
  import pr_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  output logic              pair_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic [PIDX_W-1:0] pair_idx_o
);
  localparam logic [IDX_W-1:0]  BYTE_LIM = IDX_W'(NUM_BYTES);
  localparam logic [PIDX_W-1:0] PAIR_LIM = PIDX_W'(NUM_PAIRS);

  assign pair_o     = sel_i[SEL_W-1];
  assign byte_idx_o = sel_i[IDX_W-1:0];
  // high-byte index of a pair is even; bit 0 is don't-care
  assign pair_idx_o = sel_i[IDX_W-1:1];

  always_comb begin
    if (pair_o) valid_o = (pair_idx_o < PAIR_LIM);
    else        valid_o = (byte_idx_o < BYTE_LIM);
  end
endmodule

// File: rtl/pr_step_unit.sv
module pr_step_unit
  import pr_pkg::*;
(
  input  logic [PAIR_W-1:0] val_i,
  input  step_e             code_i,
  output logic [PAIR_W-1:0] res_o
);
  always_comb begin
    unique case (code_i)
      STEP_INC:  res_o = val_i + PAIR_W'(1);
      STEP_DEC:  res_o = val_i - PAIR_W'(1);
      STEP_INC2: res_o = val_i + PAIR_W'(2);
      default:   res_o = val_i;
    endcase
  end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import pr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_en_i,
  input  logic [1:0]        step_i,
  input  logic [PAIR_W-1:0] bus_i,
  output logic [PAIR_W-1:0] bus_o,
  output logic [PAIR_W-1:0] bc_o,
  output logic [PAIR_W-1:0] de_o,
  output logic [PAIR_W-1:0] hl_o,
  output logic [PAIR_W-1:0] wz_o,
  output logic [PAIR_W-1:0] pc_o,
  output logic [PAIR_W-1:0] sp_o
);
  logic [BYTE_W-1:0] bytes_q [NUM_BYTES];
  logic [PAIR_W-1:0] pair_val [NUM_PAIRS];

  logic              rd_pair, rd_valid;
  logic [IDX_W-1:0]  rd_byte_idx;
  logic [PIDX_W-1:0] rd_pair_idx;
  logic              wr_pair, wr_valid;
  logic [IDX_W-1:0]  wr_byte_idx;
  logic [PIDX_W-1:0] wr_pair_idx;

  pr_sel_decode u_rd_dec (
    .sel_i      (rd_sel_i),
    .pair_o     (rd_pair),
    .valid_o    (rd_valid),
    .byte_idx_o (rd_byte_idx),
    .pair_idx_o (rd_pair_idx)
  );

  pr_sel_decode u_wr_dec (
    .sel_i      (wr_sel_i),
    .pair_o     (wr_pair),
    .valid_o    (wr_valid),
    .byte_idx_o (wr_byte_idx),
    .pair_idx_o (wr_pair_idx)
  );

  // step source: selected pair, zero when select is not a valid pair
  logic [PAIR_W-1:0] step_src, step_res;
  logic              step_act;

  always_comb begin
    step_src = '0;
    if (wr_pair && wr_valid) step_src = pair_val[wr_pair_idx];
  end

  assign step_act = wr_pair && wr_valid && !wr_en_i && (step_i != STEP_NONE);

  pr_step_unit u_step (
    .val_i  (step_src),
    .code_i (step_e'(step_i)),
    .res_o  (step_res)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_val[p] = {bytes_q[2*p], bytes_q[2*p+1]};
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam bit IS_HI = (i % 2) == 0;
    logic pair_hit, byte_hit;
    logic [BYTE_W-1:0] bus_half, step_half;

    assign pair_hit  = wr_pair && wr_valid && (wr_pair_idx == PIDX_W'(i / 2));
    assign byte_hit  = !wr_pair && wr_valid && (wr_byte_idx == IDX_W'(i));
    assign bus_half  = IS_HI ? bus_i[PAIR_W-1:BYTE_W] : bus_i[BYTE_W-1:0];
    assign step_half = IS_HI ? step_res[PAIR_W-1:BYTE_W] : step_res[BYTE_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_q[i] <= '0;
      end else if (wr_en_i && pair_hit) begin
        bytes_q[i] <= bus_half;
      end else if (wr_en_i && byte_hit) begin
        bytes_q[i] <= bus_i[BYTE_W-1:0];
      end else if (step_act && pair_hit) begin
        bytes_q[i] <= step_half;
      end
    end
  end

  always_comb begin
    bus_o = '0;
    if (rd_en_i && rd_valid) begin
      if (rd_pair) bus_o = pair_val[rd_pair_idx];
      else         bus_o = {{BYTE_W{1'b0}}, bytes_q[rd_byte_idx]};
    end
  end

  assign bc_o = pair_val[0];
  assign de_o = pair_val[1];
  assign hl_o = pair_val[2];
  assign wz_o = pair_val[3];
  assign pc_o = pair_val[4];
  assign sp_o = pair_val[5];
endmodule

// File: rtl/pr_checker.sv
module pr_checker
  import pr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  rd_sel_i,
  input logic              rd_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic              wr_en_i,
  input logic [1:0]        step_i,
  input logic [PAIR_W-1:0] bus_i,
  input logic [PAIR_W-1:0] bus_o,
  input logic [PAIR_W-1:0] bc_o,
  input logic [PAIR_W-1:0] de_o,
  input logic [PAIR_W-1:0] hl_o,
  input logic [PAIR_W-1:0] wz_o,
  input logic [PAIR_W-1:0] pc_o,
  input logic [PAIR_W-1:0] sp_o
);
  a_r3_byte_read_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i[4]) |-> bus_o[15:8] == 8'h00);

  a_r9_read_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> bus_o == '0);

  a_r6_pc_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && wr_sel_i[4:1] == 4'b1100 && step_i == 2'b01)
      |=> pc_o == $past(pc_o) + 16'd1);

  a_r6_sp_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && wr_sel_i[4:1] == 4'b1101 && step_i == 2'b10)
      |=> sp_o == $past(sp_o) - 16'd1);

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i[4:1] == 4'b1010 && step_i != 2'b00)
      |=> hl_o == $past(bus_i));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && step_i == 2'b00)
      |=> ($stable(bc_o) && $stable(de_o) && $stable(hl_o)
           && $stable(wz_o) && $stable(pc_o) && $stable(sp_o)));
endmodule

bind pair_regfile pr_checker u_pr_checker (.*);

// File: tb/pair_regfile_bench.sv
`timescale 1ns/1ps
module pair_regfile_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_sel_i = '0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  wr_sel_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  step_i = '0;
  logic [15:0] bus_i = '0;
  logic [15:0] bus_o, bc_o, de_o, hl_o, wz_o, pc_o, sp_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk_i = ~clk_i;

  pair_regfile u_pair_regfile (.*);

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clocked operation, then return to idle
  task automatic op(logic we, logic [4:0] ws, logic [1:0] st, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = ws; step_i = st; bus_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; step_i = 2'b00;
  endtask

  task automatic peek(logic [4:0] rs, output logic [15:0] v);
    rd_en_i = 1'b1; rd_sel_i = rs; #1; v = bus_o;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1", "bc", bc_o, 16'h0); check("R1", "de", de_o, 16'h0);
    check("R1", "hl", hl_o, 16'h0); check("R1", "wz", wz_o, 16'h0);
    check("R1", "pc", pc_o, 16'h0); check("R1", "sp", sp_o, 16'h0);
    rd_en_i = 1'b0; #1;
    check("R9", "bus_o with read off", bus_o, 16'h0);
    peek(5'b11000, v); check("R5", "pc read after reset", v, 16'h0);
  endtask

  task automatic t_byte_access;
    logic [15:0] v;
    op(1, 5'd0, 2'b00, 16'hFF12);   // B
    op(1, 5'd1, 2'b00, 16'hEE34);   // C
    check("R2", "bc after B,C byte writes", bc_o, 16'h1234);
    op(1, 5'd5, 2'b00, 16'h0077);   // L only
    check("R2", "hl after L write", hl_o, 16'h0077);
    op(1, 5'd8, 2'b00, 16'h00AB);   // PC high
    check("R2", "pc after high byte write", pc_o, 16'hAB00);
    op(1, 5'd11, 2'b00, 16'h00CD);  // SP low
    check("R11", "sp after low byte write", sp_o, 16'h00CD);
    peek(5'd1, v); check("R3", "read C", v, 16'h0034);
    peek(5'd8, v); check("R3", "read PC high", v, 16'h00AB);
    peek(5'd4, v); check("R3", "read H", v, 16'h0000);
  endtask

  task automatic t_pair_access;
    logic [15:0] v;
    op(1, 5'b10010, 2'b00, 16'hBEEF);
    check("R4", "de pair write", de_o, 16'hBEEF);
    peek(5'b10010, v); check("R5", "de pair read", v, 16'hBEEF);
    peek(5'd2, v); check("R3", "D byte of pair", v, 16'h00BE);
    op(1, 5'b11011, 2'b00, 16'h1357);  // bit0 set, still SP
    check("R4", "sp via odd code", sp_o, 16'h1357);
    peek(5'b10111, v); check("R5", "wz read via odd code", v, wz_o);
  endtask

  task automatic t_step;
    op(1, 5'b11000, 2'b00, 16'hFFFF);
    op(0, 5'b11000, 2'b01, 16'h0);
    check("R6", "pc inc wrap", pc_o, 16'h0000);
    op(1, 5'b11010, 2'b00, 16'h0000);
    op(0, 5'b11010, 2'b10, 16'h0);
    check("R6", "sp dec wrap", sp_o, 16'hFFFF);
    op(1, 5'b10100, 2'b00, 16'h00FE);
    op(0, 5'b10100, 2'b11, 16'h0);
    check("R6", "hl +2 carry", hl_o, 16'h0100);
    op(1, 5'b10000, 2'b00, 16'hFFFF);
    op(0, 5'b10000, 2'b11, 16'h0);
    check("R6", "bc +2 wrap", bc_o, 16'h0001);
    op(0, 5'b10000, 2'b00, 16'h0);
    check("R6", "step none", bc_o, 16'h0001);
    check("R6", "other pair untouched", hl_o, 16'h0100);
  endtask

  task automatic t_priority;
    op(1, 5'b10000, 2'b01, 16'h5555);
    check("R7", "write beats inc", bc_o, 16'h5555);
    op(1, 5'b11010, 2'b10, 16'h2000);
    check("R7", "write beats dec", sp_o, 16'h2000);
  endtask

  task automatic t_simul;
    op(1, 5'b10110, 2'b00, 16'h4321);
    op(1, 5'b11000, 2'b00, 16'h0010);
    @(negedge clk_i);
    rd_en_i = 1; rd_sel_i = 5'b10110; wr_en_i = 1; wr_sel_i = 5'b11000; #1;
    bus_i = bus_o;
    check("R8", "bus_o before edge", bus_o, 16'h4321);
    @(posedge clk_i); #1;
    wr_en_i = 0;
    check("R8", "pc loaded from wz", pc_o, 16'h4321);
    check("R8", "wz kept", wz_o, 16'h4321);
    // read and write of the same pair: read sees old value
    @(negedge clk_i);
    rd_sel_i = 5'b11000; wr_en_i = 1; wr_sel_i = 5'b11000; bus_i = 16'h9999; #1;
    check("R8", "same pair read before edge", bus_o, 16'h4321);
    @(posedge clk_i); #1;
    wr_en_i = 0;
    check("R8", "same pair written", pc_o, 16'h9999);
  endtask

  task automatic t_output_off;
    rd_sel_i = 5'b11000; rd_en_i = 0; #1;
    check("R9", "pair read disabled", bus_o, 16'h0);
    rd_sel_i = 5'd1; #1;
    check("R9", "byte read disabled", bus_o, 16'h0);
  endtask

  task automatic t_unused;
    logic [15:0] v;
    logic [15:0] s_bc, s_de, s_hl, s_wz, s_pc, s_sp;
    s_bc = bc_o; s_de = de_o; s_hl = hl_o; s_wz = wz_o; s_pc = pc_o; s_sp = sp_o;
    op(1, 5'd12, 2'b00, 16'hA5A5);
    op(1, 5'd15, 2'b00, 16'h5A5A);
    op(1, 5'b11100, 2'b00, 16'h1111);
    op(0, 5'b11110, 2'b01, 16'h0);
    op(0, 5'd4, 2'b01, 16'h0);      // step with byte select
    op(0, 5'd9, 2'b11, 16'h0);
    check("R10", "bc unchanged", bc_o, s_bc);
    check("R10", "de unchanged", de_o, s_de);
    check("R10", "hl unchanged", hl_o, s_hl);
    check("R10", "wz unchanged", wz_o, s_wz);
    check("R10", "pc unchanged", pc_o, s_pc);
    check("R10", "sp unchanged", sp_o, s_sp);
    peek(5'd13, v);     check("R10", "read byte 13", v, 16'h0);
    peek(5'b11100, v);  check("R10", "read pair code 11100", v, 16'h0);
    rd_en_i = 0;
  endtask

  initial begin
    #200000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_byte_access();
    t_pair_access();
    t_step();
    t_priority();
    t_simul();
    t_output_off();
    t_unused();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule